// File: doc/BRIEF.md
# MDIO Management Bus Master (Clause 22 and Clause 45)

This block is the management-bus master that a host uses to reach the registers of Ethernet PHYs. The host sees four small registers on a simple write/read port: a clock and mode register, a command register, a write-data register and a read-data register. Writing the command register starts one serial frame on the MDC/MDIO pair. The block can send the frame with a run of preamble ones. It turns the line around for reads and gathers the 16 returned bits. It then reports, through pending and valid flags, when the data can be used.

One command register covers both framing variants. The mode bit selects how the 2-bit operation code and the 5-bit address field are read. In clause 45 mode that field names the MMD device, and the register number itself goes out first in an address frame, taken from the write-data register. A full clause 45 register read is therefore two commands: an address frame, then a read frame to the same port and device.

Top module: `mdio_master`

## Requirements
- R1: After reset MDC is low, MDIO is not driven, the read-data and write-data registers read zero, and the clock/mode register (offset 0) reads divider 4, preamble off, clause 22 mode.
- R2: Every frame bit lasts 2×DIV system clocks, with MDC low for the first DIV and high for the last DIV, where DIV is bits [7:0] of offset 0. MDC stays low between frames.
- R3: When bit 8 of offset 0 is set, each frame begins with 32 driven ones. When it is clear, the frame begins directly with the start code.
- R4: In clause 22 mode (bit 9 of offset 0 clear), the frame sent is: start 01, then opcode 01 for command code 0 (write) or 10 for code 1 (read), with only bit 0 of the code decoded. Then come the 5-bit port address, the 5-bit register address, turnaround 10 and the 16 write-data bits, all MSB first.
- R5: In clause 45 mode (bit 9 set), the start code is 00 and the command codes 0, 1, 2, 3 (address, write, read with increment, read) go out as opcodes 00, 01, 10, 11. The 5-bit address field goes out as the device address, and address and write frames carry the write-data register as their 16 data bits.
- R6: For read frames the master releases MDIO for both turnaround bits and all 16 data bits. It samples MDIO on each rising MDC edge of the data bits, and the result appears in read-data register (offset 3) bits [15:0] once the frame ends.
- R7: Read-data bit 17 (valid) is cleared when a read frame starts. At the end of the frame it is set only if MDIO was low at the rising MDC edge of the second turnaround bit.
- R8: Read-data bit 16 is set exactly while a read frame runs, and write-data bit 16 is set exactly while an address or write frame runs. Both clear in the cycle the last bit ends.
- R9: A command written while a frame is in progress is dropped. The running frame continues unchanged and no frame follows it.
- R10: Write-data register (offset 2) bits [15:0] read back the value last written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset: 0 clock/mode, 1 command, 2 write data, 3 read data |
| bus_wdata | input | 18 | Write data; command layout: code [17:16], port [9:5], register/device [4:0] |
| bus_rdata | output | 18 | Read data of the register selected by bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
A command written in cycle T is accepted at the next edge. From that edge, bit b of the frame occupies cycles 2·DIV·b through 2·DIV·(b+1)−1. MDC rises DIV cycles into each bit, and the pending flags and captured read data change exactly 2·DIV·N cycles after acceptance, where N is 32 or 64 bits. The bench holds its own count of elapsed cycles from acceptance. It derives the expected MDC level, drive enable, wire bit and register flags for every cycle and compares them at the falling system-clock edge, midway between the edges at which the design changes. The modelled PHY sets up its reply bit a half clock before the sampling edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADR_W    = 5;
  localparam int DAT_W    = 16;
  localparam int PRE_LEN  = 32;
  localparam int FRM_LEN  = 4 + 2 * ADR_W + 2 + DAT_W;
  localparam int SH_W     = PRE_LEN + FRM_LEN;
  localparam int CNT_W    = $clog2(SH_W + 1);
  localparam int TA2_POS  = DAT_W + 1;
  localparam int TA1_POS  = DAT_W + 2;
  localparam int REG_W    = DAT_W + 2;

  typedef enum logic [1:0] {
    RG_CLK  = 2'd0,
    RG_CMD  = 2'd1,
    RG_WDAT = 2'd2,
    RG_RDAT = 2'd3
  } reg_sel_e;

  function automatic logic [1:0] wire_op(input logic c45, input logic [1:0] code);
    if (c45) return code;
    return code[0] ? 2'b10 : 2'b01;
  endfunction

  function automatic logic op_is_read(input logic c45, input logic [1:0] code);
    return c45 ? code[1] : code[0];
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;
  logic             mdc_q, mdc_d, at_lim;

  assign lim      = (div == '0) ? '0 : div - 1'b1;
  assign at_lim   = run && (cnt_q == lim);
  assign rise_evt = at_lim && !mdc_q;
  assign fall_evt = at_lim && mdc_q;
  assign mdc      = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (at_lim) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R2: MDC only changes once the half-period count has run out
  p_mdc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && (cnt_q != lim) |=> $stable(mdc_q));
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             c45,
  input  logic             pre_en,
  input  logic [1:0]       op,
  input  logic [ADR_W-1:0] phy,
  input  logic [ADR_W-1:0] rga,
  input  logic [DAT_W-1:0] wdata,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             mdio_i,
  output logic             busy,
  output logic             rd_act,
  output logic             done,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [DAT_W-1:0] cap,
  output logic             ta_ok
);
  localparam logic [CNT_W-1:0] REM_TA1 = CNT_W'(TA1_POS);
  localparam logic [CNT_W-1:0] REM_TA2 = CNT_W'(TA2_POS);
  localparam logic [CNT_W-1:0] REM_DAT = CNT_W'(DAT_W);
  localparam logic [CNT_W-1:0] REM_PRE = CNT_W'(FRM_LEN);

  logic [SH_W-1:0]    sh_q, sh_d;
  logic [CNT_W-1:0]   rem_q, rem_d;
  logic               busy_q, busy_d, rd_q, rd_d, ta_q, ta_d;
  logic [DAT_W-1:0]   cap_q, cap_d;
  logic [FRM_LEN-1:0] frame;

  assign frame   = {1'b0, !c45, wire_op(c45, op), phy, rga, 2'b10, wdata};
  assign busy    = busy_q;
  assign rd_act  = rd_q;
  assign cap     = cap_q;
  assign ta_ok   = ta_q;
  assign done    = busy_q && fall_evt && (rem_q == CNT_W'(1));
  assign mdio_o  = busy_q && sh_q[SH_W-1];
  assign mdio_oe = busy_q && !(rd_q && (rem_q <= REM_TA1));

  always_comb begin
    sh_d   = sh_q;
    rem_d  = rem_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    cap_d  = cap_q;
    ta_d   = ta_q;
    if (start && !busy_q) begin
      sh_d   = pre_en ? {{PRE_LEN{1'b1}}, frame} : {frame, {PRE_LEN{1'b0}}};
      rem_d  = pre_en ? CNT_W'(SH_W) : CNT_W'(FRM_LEN);
      busy_d = 1'b1;
      rd_d   = op_is_read(c45, op);
      cap_d  = '0;
      ta_d   = 1'b0;
    end else if (busy_q) begin
      if (rise_evt && rd_q) begin
        if (rem_q == REM_TA2) ta_d = !mdio_i;
        if (rem_q <= REM_DAT) cap_d = {cap_q[DAT_W-2:0], mdio_i};
      end
      if (fall_evt) begin
        if (rem_q == CNT_W'(1)) begin
          busy_d = 1'b0;
          rd_d   = 1'b0;
        end else begin
          sh_d  = sh_q << 1;
          rem_d = rem_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cap_q  <= '0;
      ta_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      rem_q  <= rem_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      cap_q  <= cap_d;
      ta_q   <= ta_d;
    end
  end

  // R3: bits ahead of the start code are driven ones
  p_preamble_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (rem_q > REM_PRE) |-> mdio_oe && mdio_o);
  // R4: the master owns the line at the first bit of every frame
  p_first_bit_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> mdio_oe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int             DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int CLK_PAD = REG_W - DIV_W - 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DIV_W-1:0] div_q;
  logic             pre_q, c45_q;
  logic [1:0]       op_q;
  logic [ADR_W-1:0] phy_q, rga_q;
  logic [DAT_W-1:0] wdat_q, rdat_q, cap;
  logic             val_q, busy, rd_act, done, ta_ok, start;
  logic             rise_evt, fall_evt, rd_pend, wr_pend;
  logic             clk_we, cmd_we, wdat_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign clk_we  = bus_we && (reg_sel_e'(bus_addr) == RG_CLK);
  assign cmd_we  = bus_we && (reg_sel_e'(bus_addr) == RG_CMD);
  assign wdat_we = bus_we && (reg_sel_e'(bus_addr) == RG_WDAT);
  assign start   = cmd_we && !busy;
  assign rd_pend = busy && rd_act;
  assign wr_pend = busy && !rd_act;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      div_q  <= DIV_RST;
      pre_q  <= 1'b0;
      c45_q  <= 1'b0;
      op_q   <= '0;
      phy_q  <= '0;
      rga_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
      val_q  <= 1'b0;
    end else begin
      if (clk_we) begin
        div_q <= bus_wdata[DIV_W-1:0];
        pre_q <= bus_wdata[DIV_W];
        c45_q <= bus_wdata[DIV_W+1];
      end
      if (start) begin
        op_q  <= bus_wdata[REG_W-1:REG_W-2];
        phy_q <= bus_wdata[2*ADR_W-1:ADR_W];
        rga_q <= bus_wdata[ADR_W-1:0];
      end
      if (wdat_we) wdat_q <= bus_wdata[DAT_W-1:0];
      if (start && op_is_read(c45_q, bus_wdata[REG_W-1:REG_W-2])) val_q <= 1'b0;
      else if (done && rd_act) begin
        rdat_q <= cap;
        val_q  <= ta_ok;
      end
    end
  end

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      RG_CLK:  bus_rdata = {{CLK_PAD{1'b0}}, c45_q, pre_q, div_q};
      RG_CMD:  bus_rdata = {op_q, {(REG_W-2-2*ADR_W){1'b0}}, phy_q, rga_q};
      RG_WDAT: bus_rdata = {1'b0, wr_pend, wdat_q};
      default: bus_rdata = {val_q, rd_pend, rdat_q};
    endcase
  end

  mdio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk(clk), .rst_n(rst_int_n), .run(busy), .div(div_q),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_engine i_engine (
    .clk(clk), .rst_n(rst_int_n), .start(start), .c45(c45_q), .pre_en(pre_q),
    .op(bus_wdata[REG_W-1:REG_W-2]), .phy(bus_wdata[2*ADR_W-1:ADR_W]),
    .rga(bus_wdata[ADR_W-1:0]), .wdata(wdat_q), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .mdio_i(mdio_i), .busy(busy), .rd_act(rd_act),
    .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cap(cap), .ta_ok(ta_ok)
  );

  // R1: between frames the bus is quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> !mdc && !mdio_oe);
  // R8: never both pending flags at once
  p_one_pending_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(rd_pend && wr_pend));
  // R9: the latched command does not move while a frame runs
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy && $past(busy) |-> $stable(op_q) && $stable(phy_q) && $stable(rga_q));
  // R7: a read that has just started never shows valid
  p_valid_clear_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rd_pend) |-> !val_q);
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/100ps
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd3;
  logic [17:0] bus_wdata = '0;
  logic [17:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_line = 1'b1;

  int total = 0, bad = 0, cyc = 0;
  bit run_chk = 0;

  // bench model state
  int          s_div = 4;
  bit          s_pre = 0, s_c45 = 0;
  logic [15:0] s_wdat = '0;
  bit          m_busy = 0, m_rd = 0, m_c45 = 0, m_ign = 0, m_ack = 1;
  logic [15:0] m_resp = '0;
  int          m_start = 0, m_n = 0;
  logic [63:0] m_fr = '0;
  logic [15:0] exp_rdat = '0;
  bit          exp_val = 0;

  always #2.5 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mdio_i = mdio_oe ? mdio_o : phy_line;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // cycle-by-cycle reference model, compared at every falling edge
  always @(negedge clk) begin
    int e, b, ph, r;
    bit x_mdc, x_oe, x_o;
    string tag;
    logic [31:0] f32;
    if (rst_n && run_chk) begin
      e = 0; r = 0;
      if (m_busy) begin
        e = cyc - m_start;
        if (e >= m_n * 2 * s_div) begin
          m_busy = 0;
          m_ign = 0;
          if (m_rd) begin
            exp_rdat = m_ack ? m_resp : 16'hFFFF;
            exp_val = m_ack;
          end
        end
      end
      if (m_busy) begin
        b = e / (2 * s_div);
        ph = e % (2 * s_div);
        r = m_n - b;
        x_mdc = (ph >= s_div);
        x_oe = !(m_rd && r <= 18);
        x_o = m_fr[63-b];
        if (m_ign) tag = "R9";
        else if (r > 32) tag = "R3";
        else if (m_rd && r <= 18) tag = "R6";
        else tag = m_c45 ? "R5" : "R4";
        if (m_rd && r <= 18)
          phy_line = (r == 18) ? 1'b1 : (r == 17) ? !m_ack : (m_ack ? m_resp[r-1] : 1'b1);
        else phy_line = 1'b1;
      end else begin
        x_mdc = 0; x_oe = 0; x_o = 0;
        tag = "R2";
        phy_line = 1'b1;
      end
      chk(mdc === x_mdc, m_ign ? "R9" : "R2", int'(mdc), int'(x_mdc));
      chk(mdio_oe === x_oe, tag, int'(mdio_oe), int'(x_oe));
      if (x_oe) chk(mdio_o === x_o, tag, int'(mdio_o), int'(x_o));
      if (!bus_we && bus_addr == 2'd3) begin
        chk(bus_rdata[16] === (m_busy && m_rd), "R8", int'(bus_rdata[16]), int'(m_busy && m_rd));
        chk(bus_rdata[17] === exp_val, "R7", int'(bus_rdata[17]), int'(exp_val));
        chk(bus_rdata[15:0] === exp_rdat, "R6", int'(bus_rdata[15:0]), int'(exp_rdat));
      end
      if (!bus_we && bus_addr == 2'd2) begin
        chk(bus_rdata[16] === (m_busy && !m_rd), "R8", int'(bus_rdata[16]), int'(m_busy && !m_rd));
        chk(bus_rdata[15:0] === s_wdat, "R10", int'(bus_rdata[15:0]), int'(s_wdat));
      end
      if (bus_we && bus_addr == 2'd0) begin
        s_div = int'(bus_wdata[7:0]);
        s_pre = bus_wdata[8];
        s_c45 = bus_wdata[9];
      end
      if (bus_we && bus_addr == 2'd2) s_wdat = bus_wdata[15:0];
      if (bus_we && bus_addr == 2'd1) begin
        if (m_busy) m_ign = 1;
        else begin
          m_c45 = s_c45;
          m_rd = s_c45 ? bus_wdata[17] : bus_wdata[16];
          f32[31:30] = s_c45 ? 2'b00 : 2'b01;
          f32[29:28] = s_c45 ? bus_wdata[17:16] : (bus_wdata[16] ? 2'b10 : 2'b01);
          f32[27:18] = bus_wdata[9:0];
          f32[17:16] = 2'b10;
          f32[15:0] = s_wdat;
          m_fr = s_pre ? {32'hFFFF_FFFF, f32} : {f32, 32'h0};
          m_n = s_pre ? 64 : 32;
          m_start = cyc + 1;
          m_busy = 1;
          if (m_rd) exp_val = 0;
        end
      end
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [17:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic peek_wdat();
    @(posedge clk); #1 bus_addr = 2'd2;
    @(posedge clk); #1 bus_addr = 2'd3;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: values held during and right after reset
    @(negedge clk);
    chk(mdc === 1'b0, "R1", int'(mdc), 0);
    chk(mdio_oe === 1'b0, "R1", int'(mdio_oe), 0);
    chk(bus_rdata === 18'h0, "R1", int'(bus_rdata), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 bus_addr = 2'd0;
    @(negedge clk);
    chk(bus_rdata === 18'h004, "R1", int'(bus_rdata), 4);
    @(posedge clk); #1 bus_addr = 2'd2;
    @(negedge clk);
    chk(bus_rdata === 18'h0, "R1", int'(bus_rdata), 0);
    @(posedge clk); #1 bus_addr = 2'd3;
    run_chk = 1;

    // clause 22 write, no preamble, DIV 2 (R2, R4, R8, R10)
    wr_reg(2'd0, 18'h002);
    wr_reg(2'd2, 18'h0A5C3);
    peek_wdat();
    wr_reg(2'd1, {2'd0, 6'd0, 5'd5, 5'd3});
    peek_wdat();
    wait_idle();
    // clause 22 read with preamble, DIV 3, PHY answers (R3, R6, R7)
    m_ack = 1; m_resp = 16'h1234;
    wr_reg(2'd0, 18'h103);
    wr_reg(2'd1, {2'd1, 6'd0, 5'd17, 5'd2});
    wait_idle();
    // clause 22 read with no PHY answer: valid stays clear (R7)
    m_ack = 0;
    wr_reg(2'd1, {2'd1, 6'd0, 5'd31, 5'd1});
    wait_idle();
    // clause 45 address then read, preamble, DIV 2 (R5)
    m_ack = 1; m_resp = 16'hBEEF;
    wr_reg(2'd0, 18'h302);
    wr_reg(2'd2, 18'h00102);
    wr_reg(2'd1, {2'd0, 6'd0, 5'd9, 5'd1});
    wait_idle();
    wr_reg(2'd1, {2'd3, 6'd0, 5'd9, 5'd1});
    wait_idle();
    // clause 45 read with increment, no preamble, DIV 1
    m_resp = 16'h0F0F;
    wr_reg(2'd0, 18'h201);
    wr_reg(2'd1, {2'd2, 6'd0, 5'd4, 5'd30});
    wait_idle();
    // clause 45 write, then a read command while busy is dropped (R9)
    wr_reg(2'd2, 18'h05A5A);
    wr_reg(2'd1, {2'd1, 6'd0, 5'd2, 5'd3});
    repeat (5) @(posedge clk);
    wr_reg(2'd1, {2'd3, 6'd0, 5'd7, 5'd7});
    wait_idle();
    repeat (10) @(posedge clk);
    // R9: no frame followed the dropped command
    @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R9", int'(mdio_oe), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule